// File: doc/BRIEF.md
# Interrupt Pin Redirection and Delivery

This block watches a bank of external interrupt pins and turns each one into a delivery message, steered by a per-pin 64-bit redirection entry. The entries come from a neighbouring configuration table as one flat input vector. For every pin the block applies the entry's polarity, trigger and mask settings, and keeps a pending flag for edge-triggered pins or a remote-acknowledge flag for level-triggered pins. When one or more pins want service, the lowest-numbered pin wins. Its vector, delivery mode, destination mode and destination are then captured into an output register.

The message leaves on a valid/ready handshake, and only one message is in flight at a time. Once `msg_valid` rises, it and every message field hold steady until a cycle in which `msg_ready` is high. That cycle completes the transfer. The downstream side may stall for as long as it likes, and no pin state is lost while it does. After a completed transfer the block takes one idle cycle before it presents the next message.

The block returns two bits per pin to the table. One is a delivery-status bit, set while that pin's message is in flight. The other is a remote-acknowledge bit, set on level-triggered pins after acceptance. An end-of-interrupt strobe carries a vector, and it clears the remote-acknowledge bit of every pin whose entry holds that vector.

Top module: `irq_route_unit`

## Requirements
- R1: The message carries the vector from entry bits 7:0, the delivery mode from bits 10:8 unchanged (any of the codes 000, 001, 010, 100, 101, 111) and the destination mode from bit 11 (0 physical, 1 logical).
- R2: With bit 11 at 0 the message destination is entry bits 59:56 with the upper four bits zero; with bit 11 at 1 it is the full field in bits 63:56.
- R3: Bit 13 sets polarity: at 0 a high pin is active, at 1 a low pin is active.
- R4: With bit 15 at 0 (edge), an inactive-to-active transition of an unmasked pin latches a pending flag. Further transitions while the flag is set merge into one message.
- R5: With bit 16 at 1 the pin produces no message, and transitions seen while masked are not latched.
- R6: With bit 15 at 1 (level), an active unmasked pin is sent. Its acceptance sets that pin's remote-acknowledge bit, and no further message goes out for the pin until the bit is cleared.
- R7: An end-of-interrupt clears the remote-acknowledge bit only of pins whose entry vector equals the strobe's vector; others keep it.
- R8: Among requesting pins the lowest-numbered is sent first, and only one message is outstanding at a time.
- R9: While `msg_valid` is high and `msg_ready` is low, valid and all message fields stay unchanged.
- R10: A pin's delivery-status bit is 1 exactly while its message is presented, and it clears, along with the edge pending flag, on the handshake cycle.
- R11: After reset no message is valid and all delivery-status and remote-acknowledge bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NUM_PINS | External interrupt pins |
| cfg_table | input | NUM_PINS*64 | Redirection entries, pin n at bits n*64+63 : n*64 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode, 1 logical |
| msg_dest | output | 8 | Destination |
| dlv_status | output | NUM_PINS | Per-pin delivery status |
| remote_irr | output | NUM_PINS | Per-pin remote-acknowledge flag |

## Verification
The assertions check several properties on every cycle. They cover the stall rule on the output, the one-cycle gap after a completed transfer, and the zero upper destination bits in physical mode. They also check that at most one delivery-status bit is set and that it agrees with `msg_valid`, and that a pending flag appears only after an unmasked edge. The ordering properties need a sequence of stimulus, so only the bench scenarios can show them. These are the ascending priority across all pins, the merging of repeated edges, the suppression of masked edges, the polarity inversion, and the remote-acknowledge cycle with matching and non-matching end-of-interrupt vectors.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENTRY_W = 64;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       active_low;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } rte_t;

  function automatic rte_t rte_decode(input logic [ENTRY_W-1:0] e);
    rte_t r;
    r.vector     = e[7:0];
    r.mode       = e[10:8];
    r.logical    = e[11];
    r.active_low = e[13];
    r.level      = e[15];
    r.mask       = e[16];
    r.dest       = e[63:56];
    return r;
  endfunction

endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       active_low,
  input  logic       level,
  input  logic       mask,
  input  logic [7:0] vector,
  input  logic       accept,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  output logic       req,
  output logic       rirr
);

  logic act, prev_act, pend, edge_hit;

  assign act      = pin ^ active_low;
  assign edge_hit = act & ~prev_act & ~mask & ~level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      pend     <= 1'b0;
      rirr     <= 1'b0;
    end else begin
      prev_act <= act;
      pend     <= edge_hit | (pend & ~accept);
      if (accept && level)
        rirr <= 1'b1;
      else if (eoi_valid && eoi_vector == vector)
        rirr <= 1'b0;
    end
  end

  assign req = level ? (act & ~mask & ~rirr) : (pend & ~mask);

  // R5
  pend_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(!mask && !level && act));

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irq_pins,
  input  logic [NUM_PINS*ENTRY_W-1:0] cfg_table,
  input  logic                        eoi_valid,
  input  logic [7:0]                  eoi_vector,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [7:0]                  msg_vector,
  output logic [2:0]                  msg_mode,
  output logic                        msg_logical,
  output logic [7:0]                  msg_dest,
  output logic [NUM_PINS-1:0]         dlv_status,
  output logic [NUM_PINS-1:0]         remote_irr
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  rte_t               rte [NUM_PINS];
  logic [NUM_PINS-1:0] req_vec;
  logic               busy, msg_done, pick_any;
  logic [IDX_W-1:0]   cur_pin, pick_idx;

  assign msg_done = busy & msg_ready;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign rte[i] = rte_decode(cfg_table[i*ENTRY_W +: ENTRY_W]);

    irq_pin_ctrl u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (irq_pins[i]),
      .active_low (rte[i].active_low),
      .level      (rte[i].level),
      .mask       (rte[i].mask),
      .vector     (rte[i].vector),
      .accept     (msg_done && cur_pin == IDX_W'(i)),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .req        (req_vec[i]),
      .rirr       (remote_irr[i])
    );

    assign dlv_status[i] = busy && cur_pin == IDX_W'(i);
  end

  irq_lowest_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req (req_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_pin     <= '0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
    end else if (msg_done) begin
      busy <= 1'b0;
    end else if (!busy && pick_any) begin
      busy        <= 1'b1;
      cur_pin     <= pick_idx;
      msg_vector  <= rte[pick_idx].vector;
      msg_mode    <= rte[pick_idx].mode;
      msg_logical <= rte[pick_idx].logical;
      msg_dest    <= rte[pick_idx].logical ? rte[pick_idx].dest
                                           : {4'h0, rte[pick_idx].dest[3:0]};
    end
  end

  assign msg_valid = busy;

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
      $stable(msg_mode) && $stable(msg_logical) && $stable(msg_dest));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R2
  phys_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical |-> msg_dest[7:4] == 4'h0);

  // R10
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_status) && (msg_valid == (dlv_status != '0)));

endmodule

// File: tb/irq_route_unit_tb_top.sv
`timescale 1ns/1ps
module irq_route_unit_tb_top;

  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     irq_pins;
  logic [NP*64-1:0]  cfg_table;
  logic              eoi_valid;
  logic [7:0]        eoi_vector;
  logic              msg_valid, msg_ready, msg_logical;
  logic [7:0]        msg_vector, msg_dest;
  logic [2:0]        msg_mode;
  logic [NP-1:0]     dlv_status, remote_irr;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_route_unit #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .cfg_table(cfg_table),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
    .dlv_status(dlv_status), .remote_irr(remote_irr)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                     input logic lg, input logic pol, input logic lvl,
                                     input logic msk, input logic [7:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = mode; e[11] = lg; e[13] = pol;
    e[15] = lvl;  e[16] = msk;    e[63:56] = dst;
    return e;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic take();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [2:0] modes [6];
    modes = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b111};
    rst_n = 1'b0; irq_pins = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
    for (int p = 0; p < NP; p++) cfg_table[p*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!msg_valid, "R11 valid", msg_valid, 0);
    chk(dlv_status == '0, "R11 status", dlv_status, 0);
    chk(remote_irr == '0, "R11 rirr", remote_irr, 0);

    // Sweep every pin in edge mode: fields, destination, stall, status
    for (int p = 0; p < NP; p++) begin
      logic [7:0] dst = 8'hA0 + 8'(p);
      logic lg = p[0];
      logic [7:0] exp_dst = lg ? dst : {4'h0, dst[3:0]};
      cfg_table[p*64 +: 64] = mk(8'h30 + 8'(p), modes[p % 6], lg, 1'b0, 1'b0, 1'b0, dst);
      irq_pins[p] = 1'b1;
      wait_msg(got);
      chk(got, "R4 edge message", got, 1);
      chk(msg_vector == 8'h30 + 8'(p), "R1 vector", msg_vector, 8'h30 + 8'(p));
      chk(msg_mode == modes[p % 6], "R1 mode", msg_mode, modes[p % 6]);
      chk(msg_logical == lg, "R1 dest mode", msg_logical, lg);
      chk(msg_dest == exp_dst, "R2 destination", msg_dest, exp_dst);
      chk(dlv_status == (NP'(1) << p), "R10 status set", dlv_status, NP'(1) << p);
      idle(3);
      chk(msg_valid && msg_vector == 8'h30 + 8'(p), "R9 stall hold", msg_vector, 8'h30 + 8'(p));
      take();
      chk(!msg_valid, "R10 valid clears", msg_valid, 0);
      chk(dlv_status == '0, "R10 status clears", dlv_status, 0);
      irq_pins[p] = 1'b0;
      idle(3);
      chk(!msg_valid, "R4 single message", msg_valid, 0);
      cfg_table[p*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);
    end

    // R4 merge repeated edges into one message
    cfg_table[5*64 +: 64] = mk(8'h55, 3'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    for (int k = 0; k < 3; k++) begin
      irq_pins[5] = 1'b1; idle(2); irq_pins[5] = 1'b0; idle(2);
    end
    chk(msg_valid && msg_vector == 8'h55, "R4 merged first", msg_vector, 8'h55);
    take();
    idle(5);
    chk(!msg_valid, "R4 merged no repeat", msg_valid, 0);
    cfg_table[5*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);

    // R5 masked edge is not latched
    cfg_table[7*64 +: 64] = mk(8'h57, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    irq_pins[7] = 1'b1; idle(2); irq_pins[7] = 1'b0;
    idle(4);
    chk(!msg_valid, "R5 masked silent", msg_valid, 0);
    cfg_table[7*64 +: 64] = mk(8'h57, 3'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    idle(5);
    chk(!msg_valid, "R5 no latch after unmask", msg_valid, 0);
    cfg_table[7*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);

    // R3 active-low pin
    irq_pins[9] = 1'b1;
    idle(2);
    cfg_table[9*64 +: 64] = mk(8'h59, 3'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02);
    idle(4);
    chk(!msg_valid, "R3 high is inactive", msg_valid, 0);
    irq_pins[9] = 1'b0;
    wait_msg(got);
    chk(got && msg_vector == 8'h59, "R3 low fires", msg_vector, 8'h59);
    take();
    irq_pins[9] = 1'b1;
    idle(4);
    chk(!msg_valid, "R3 release silent", msg_valid, 0);
    cfg_table[9*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);
    irq_pins[9] = 1'b0;
    idle(2);

    // R6 / R7 level pin with end-of-interrupt
    cfg_table[12*64 +: 64] = mk(8'h77, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3);
    irq_pins[12] = 1'b1;
    wait_msg(got);
    chk(got && msg_vector == 8'h77, "R6 level fires", msg_vector, 8'h77);
    chk(msg_dest == 8'hC3, "R2 logical dest", msg_dest, 8'hC3);
    take();
    chk(remote_irr == (NP'(1) << 12), "R6 rirr set", remote_irr, NP'(1) << 12);
    idle(5);
    chk(!msg_valid, "R6 held off", msg_valid, 0);
    eoi_valid = 1'b1; eoi_vector = 8'h78; @(negedge clk); eoi_valid = 1'b0;
    chk(remote_irr[12], "R7 mismatched eoi keeps", remote_irr, NP'(1) << 12);
    idle(4);
    chk(!msg_valid, "R7 still held off", msg_valid, 0);
    eoi_valid = 1'b1; eoi_vector = 8'h77; @(negedge clk); eoi_valid = 1'b0;
    chk(!remote_irr[12], "R7 matched eoi clears", remote_irr, 0);
    wait_msg(got);
    chk(got && msg_vector == 8'h77, "R6 refire while active", msg_vector, 8'h77);
    take();
    irq_pins[12] = 1'b0;
    eoi_valid = 1'b1; eoi_vector = 8'h77; @(negedge clk); eoi_valid = 1'b0;
    idle(5);
    chk(!msg_valid && remote_irr == '0, "R6 inactive silent", remote_irr, 0);
    cfg_table[12*64 +: 64] = mk(8'h0, 3'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0);

    // R8 all pins at once, ascending order
    for (int p = 0; p < NP; p++)
      cfg_table[p*64 +: 64] = mk(8'h40 + 8'(p), 3'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
    idle(2);
    irq_pins = '1;
    for (int p = 0; p < NP; p++) begin
      wait_msg(got);
      chk(got && msg_vector == 8'h40 + 8'(p), "R8 order", msg_vector, 8'h40 + 8'(p));
      chk($countones(dlv_status) == 1, "R8 one outstanding", dlv_status, 1);
      take();
    end
    idle(4);
    chk(!msg_valid, "R8 drained", msg_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule